// File: doc/BRIEF.md
# Saturating Element Narrowing Stage

This stage sits at the end of an integer vector datapath. It takes one element result at a time. The result arrives already computed at the widest width in use, that is, the larger of the source and destination widths. The stage clamps the value into the range of the selected destination element width, treating that range as signed or unsigned. It then narrows the value to that width.

Each element leaves with its own 4-bit condition field. The field has three sign flags, taken from the narrowed value, and an overflow flag that reports whether this element was clamped. No overflow or carry state is kept or accumulated from one element to the next. Operations that produce a carry must not be sent through this stage, because the overflow flag would collide with carry storage. The stage is one register deep. A new element can be accepted on every cycle.

Top module: `sat_unit`

## Requirements
- R1: In unsigned mode (`in_sgn`=0), the element leaving the stage equals the input clamped to the range 0 to 2^w-1. Here w is the destination width and the input is read as a two's-complement value of `RES_W` bits. A negative input therefore gives 0.
- R2: In signed mode (`in_sgn`=1), the element equals the input clamped to the range -2^(w-1) to 2^(w-1)-1. It is delivered as a w-bit two's-complement pattern.
- R3: When condition recording is on, bit 0 of `out_cond` is 1 exactly when the element was clamped. It depends only on that element, so an unclamped element that follows a clamped one shows 0.
- R4: When condition recording is on, `out_cond` bit 3 (lt), bit 2 (gt) and bit 1 (eq) come from comparing the narrowed w-bit element, read as signed, against zero. Exactly one of the three bits is set.
- R5: When condition recording is off (`in_rec`=0), `out_cond` is 0 and `out_cond_we` is 0.
- R6: Width select code k gives w = `MIN_EW`·2^k. With the defaults, codes 0, 1, 2 and 3 give 8, 16, 32 and 64 bits. Bits of `out_elem` at and above w are 0.
- R7: If w is at least `RES_W`, the signed mode never clamps, and the unsigned mode clamps only negative inputs.
- R8: An element presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. `out_cond_we` is high only together with `out_valid`.
- R9: While reset (`rst_n` low, synchronous) is applied, `out_valid`, `out_elem`, `out_cond` and `out_cond_we` are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An element is present on the inputs |
| in_res | input | RES_W | Wide result, two's complement |
| in_sel | input | SEL_W | Destination width code |
| in_sgn | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| in_rec | input | 1 | Record a condition field for this element |
| out_valid | output | 1 | Output element valid |
| out_elem | output | OUT_W | Narrowed element, zero above w |
| out_cond | output | 4 | {lt, gt, eq, ov} |
| out_cond_we | output | 1 | Condition field write enable |

## Verification
The bench builds the stage with `RES_W`=10, `MIN_EW`=2 and `NUM_EW`=4. This gives destination widths of 2, 4, 8 and 16 bits.

With this configuration, every 10-bit input can be swept under every combination of width code, sign mode and recording. The sweep covers all clamp boundaries on both sides of each width. It also covers the 16-bit width, which is wider than the input and therefore exercises the no-clamp behaviour of R7.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // Condition field bit positions
  localparam int CF_LT = 3;
  localparam int CF_GT = 2;
  localparam int CF_EQ = 1;
  localparam int CF_OV = 0;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic ov;
  } cond_t;

  // Element width in bits for a width-select code
  function automatic int elem_bits(input int min_ew, input int code);
    return min_ew << code;
  endfunction
endpackage

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int RES_W  = 64,
  parameter int MIN_EW = 8,
  parameter int NUM_EW = 4,
  localparam int SEL_W = $clog2(NUM_EW),
  localparam int OUT_W = MIN_EW << (NUM_EW - 1)
) (
  input  logic [RES_W-1:0] res,
  input  logic [SEL_W-1:0] sel,
  input  logic             sgn,
  output logic [OUT_W-1:0] elem,
  output logic             sat_hi,
  output logic             sat_lo
);
  localparam int EXT_W = ((RES_W > OUT_W) ? RES_W : OUT_W) + 2;
  localparam logic [EXT_W-1:0] ONE = {{(EXT_W-1){1'b0}}, 1'b1};

  logic signed [EXT_W-1:0] smax_a [NUM_EW];
  logic signed [EXT_W-1:0] smin_a [NUM_EW];
  logic signed [EXT_W-1:0] umax_a [NUM_EW];
  logic        [OUT_W-1:0] mask_a [NUM_EW];

  for (genvar k = 0; k < NUM_EW; k++) begin : g_bound
    localparam int W = sat_pkg::elem_bits(MIN_EW, k);
    localparam logic [EXT_W-1:0] HALF = ONE << (W - 1);
    localparam logic [EXT_W-1:0] FULL = ONE << W;
    localparam logic [EXT_W-1:0] UMAX = FULL - ONE;
    assign smax_a[k] = $signed(HALF - ONE);
    assign smin_a[k] = $signed(~HALF + ONE);
    assign umax_a[k] = $signed(UMAX);
    assign mask_a[k] = UMAX[OUT_W-1:0];
  end

  logic signed [EXT_W-1:0] x_ext, hi_b, lo_b, clamped;

  assign x_ext = $signed({{(EXT_W-RES_W){res[RES_W-1]}}, res});
  assign hi_b  = sgn ? smax_a[sel] : umax_a[sel];
  assign lo_b  = sgn ? smin_a[sel] : '0;

  assign sat_hi = x_ext > hi_b;
  assign sat_lo = x_ext < lo_b;

  always_comb begin
    if (sat_hi)      clamped = hi_b;
    else if (sat_lo) clamped = lo_b;
    else             clamped = x_ext;
  end

  assign elem = clamped[OUT_W-1:0] & mask_a[sel];
endmodule

// File: rtl/sat_cond.sv
module sat_cond #(
  parameter int MIN_EW = 8,
  parameter int NUM_EW = 4,
  localparam int SEL_W = $clog2(NUM_EW),
  localparam int OUT_W = MIN_EW << (NUM_EW - 1)
) (
  input  logic [OUT_W-1:0] elem,
  input  logic [SEL_W-1:0] sel,
  input  logic             ov,
  input  logic             rec,
  output sat_pkg::cond_t   cond
);
  logic [NUM_EW-1:0] sign_a;

  for (genvar k = 0; k < NUM_EW; k++) begin : g_sign
    assign sign_a[k] = elem[sat_pkg::elem_bits(MIN_EW, k) - 1];
  end

  logic neg, zero;
  assign neg  = sign_a[sel];
  assign zero = (elem == '0);

  always_comb begin
    cond = '0;
    if (rec) begin
      cond.lt = neg;
      cond.gt = !neg && !zero;
      cond.eq = zero;
      cond.ov = ov;
    end
  end
endmodule

// File: rtl/sat_unit.sv
module sat_unit #(
  parameter int RES_W  = 64,
  parameter int MIN_EW = 8,
  parameter int NUM_EW = 4,
  localparam int SEL_W = $clog2(NUM_EW),
  localparam int OUT_W = MIN_EW << (NUM_EW - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RES_W-1:0] in_res,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             in_sgn,
  input  logic             in_rec,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_elem,
  output logic [3:0]       out_cond,
  output logic             out_cond_we
);
  logic [OUT_W-1:0] nx_elem;
  logic             sat_hi, sat_lo, clamp_ov;
  sat_pkg::cond_t   nx_cond;

  sat_clamp #(.RES_W(RES_W), .MIN_EW(MIN_EW), .NUM_EW(NUM_EW)) u_clamp (
    .res(in_res), .sel(in_sel), .sgn(in_sgn),
    .elem(nx_elem), .sat_hi(sat_hi), .sat_lo(sat_lo)
  );

  assign clamp_ov = sat_hi | sat_lo;

  sat_cond #(.MIN_EW(MIN_EW), .NUM_EW(NUM_EW)) u_cond (
    .elem(nx_elem), .sel(in_sel), .ov(clamp_ov), .rec(in_rec), .cond(nx_cond)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_elem    <= '0;
      out_cond    <= '0;
      out_cond_we <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_elem    <= in_valid ? nx_elem : '0;
      out_cond    <= in_valid ? nx_cond : '0;
      out_cond_we <= in_valid && in_rec;
    end
  end
endmodule

// File: rtl/sat_unit_chk.sv
module sat_unit_chk #(
  parameter int RES_W  = 64,
  parameter int MIN_EW = 8,
  parameter int NUM_EW = 4,
  localparam int SEL_W = $clog2(NUM_EW),
  localparam int OUT_W = MIN_EW << (NUM_EW - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [SEL_W-1:0] in_sel,
  input logic             in_rec,
  input logic             sat_hi,
  input logic             sat_lo,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_elem,
  input logic [3:0]       out_cond,
  input logic             out_cond_we
);
  function automatic logic [OUT_W-1:0] above_w(input logic [SEL_W-1:0] s);
    logic [OUT_W-1:0] m;
    m = '0;
    for (int b = 0; b < OUT_W; b++)
      if (b >= (MIN_EW << s)) m[b] = 1'b1;
    return m;
  endfunction

  AST_SAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_hi && sat_lo)); // R3
  AST_OV_PER_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_rec |=> out_cond[0] == $past(sat_hi || sat_lo)); // R3
  AST_ONE_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_cond_we |-> $countones(out_cond[3:1]) == 1); // R4
  AST_REC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_rec |=> out_cond == 4'd0 && !out_cond_we); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_elem & above_w($past(in_sel))) == '0); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_cond_we |-> out_valid); // R8
endmodule

bind sat_unit sat_unit_chk #(.RES_W(RES_W), .MIN_EW(MIN_EW), .NUM_EW(NUM_EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel), .in_rec(in_rec),
  .sat_hi(sat_hi), .sat_lo(sat_lo), .out_valid(out_valid), .out_elem(out_elem),
  .out_cond(out_cond), .out_cond_we(out_cond_we)
);

// File: tb/test_sat_unit.sv
module test_sat_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W  = 10;
  localparam int MIN_EW = 2;
  localparam int NUM_EW = 4;
  localparam int SEL_W  = 2;
  localparam int OUT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [RES_W-1:0] in_res = '0;
  logic [SEL_W-1:0] in_sel = '0;
  logic in_sgn = 1'b0, in_rec = 1'b0;
  logic out_valid, out_cond_we;
  logic [OUT_W-1:0] out_elem;
  logic [3:0] out_cond;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_unit #(.RES_W(RES_W), .MIN_EW(MIN_EW), .NUM_EW(NUM_EW)) i_sat_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_res(in_res), .in_sel(in_sel),
    .in_sgn(in_sgn), .in_rec(in_rec), .out_valid(out_valid), .out_elem(out_elem),
    .out_cond(out_cond), .out_cond_we(out_cond_we)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply one element and check the registered result one clock later.
  task automatic apply(input int val, input int sel, input bit sgn, input bit rec,
                       output bit ov_seen);
    longint v, lo, hi, c, e;
    int w;
    bit neg, zr, ov;
    @(negedge clk);
    in_valid = 1'b1; in_res = val[RES_W-1:0]; in_sel = sel[SEL_W-1:0];
    in_sgn = sgn; in_rec = rec;
    @(negedge clk);
    in_valid = 1'b0;
    v = longint'(val[RES_W-1:0]);
    if (v >= (64'sd1 <<< (RES_W-1))) v = v - (64'sd1 <<< RES_W);
    w = MIN_EW << sel;
    if (sgn) begin lo = -(64'sd1 <<< (w-1)); hi = (64'sd1 <<< (w-1)) - 1; end
    else begin lo = 0; hi = (64'sd1 <<< w) - 1; end
    c  = (v > hi) ? hi : (v < lo) ? lo : v;
    ov = (v > hi) || (v < lo);
    e  = c & ((64'sd1 <<< w) - 1);
    neg = e[w-1];
    zr = (e == 0);
    ov_seen = out_cond[0];
    check("R8 valid", longint'(out_valid), 1);
    if (w >= RES_W && sgn) check("R7 elem", longint'(out_elem), e);
    else if (sgn)          check("R2/R6 elem", longint'(out_elem), e);
    else                   check("R1/R6 elem", longint'(out_elem), e);
    if (rec) begin
      check("R3 ov", longint'(out_cond[0]), longint'(ov));
      check("R4 lt/gt/eq", longint'(out_cond[3:1]),
            longint'({neg, !neg && !zr, zr}));
      check("R8 cond_we", longint'(out_cond_we), 1);
    end else begin
      check("R5 cond", longint'(out_cond), 0);
      check("R5 cond_we", longint'(out_cond_we), 0);
    end
  endtask

  initial begin
    bit ovs;
    // R9: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 valid", longint'(out_valid), 0);
    check("R9 elem", longint'(out_elem), 0);
    check("R9 cond", longint'(out_cond), 0);
    check("R9 cond_we", longint'(out_cond_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle valid", longint'(out_valid), 0);
    // Exhaustive sweep: rec, sign mode, width code, every input value
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < NUM_EW; k++)
          for (int x = 0; x < (1 << RES_W); x++)
            apply(x, k, s[0], r[0], ovs);
    // R3: overflow flag is not sticky across elements
    apply(200, 0, 1'b0, 1'b1, ovs);
    check("R3 clamp seen", longint'(ovs), 1);
    apply(1, 0, 1'b0, 1'b1, ovs);
    check("R3 not sticky", longint'(ovs), 0);
    // R8: output drops when no element is presented
    @(negedge clk);
    check("R8 valid drop", longint'(out_valid), 0);
    check("R8 we drop", longint'(out_cond_we), 0);
    done = 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
    end
  end

  initial begin
    wait (done || n_fail > 0 && 0);
    wait (done);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150001) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule